// File: doc/BRIEF.md
# Working Register File with Data-Space Alias and Address Pointers

This block holds the 32 eight-bit general-purpose registers of a small 8-bit RISC core. The ALU reads two operands and writes one result in the same cycle through index-addressed ports, so a register-to-register operation finishes in a single clock. The same storage is also visible to the load/store path at the bottom of data space: addresses 0x00 through 0x1F land on the registers, and the block reports whether a data-space address falls in that window.

The top six registers pair up into three 16-bit pointers that are always presented on dedicated outputs for indirect addressing; the last pair is also the address used for constant fetches from program memory. After a post-increment or pre-decrement, the address unit returns the new 16-bit value through a write-back port that updates both bytes of a pair in one edge. When several write sources aim at the same register in one cycle, a fixed priority picks the winner byte by byte.

Top module: `gpr_file`

## Requirements
- R1: Both read ports return, combinationally, the stored byte of the register selected by their 5-bit index.
- R2: Every write lands on the rising clock edge; a read of the register being written in the same cycle returns the old value, and the new value from the next cycle on.
- R3: Data-space addresses 0x00 to 0x1F map to registers 0 to 31; a data-space write (request and write-enable high) in this window updates that register, and the hit output is high exactly when the address is below 0x20.
- R4: A data-space read (request high, write-enable low) in the window loads the addressed register's value into the data-space read output at the next edge; otherwise that output holds, and reset clears it to 0x00.
- R5: A data-space access at an address of 0x20 or above changes no register and leaves the data-space read output unchanged.
- R6: The pointer outputs show register pairs 27:26 (X), 29:28 (Y) and 31:30 (Z), high byte from the odd register; Z serves as the program-memory lookup address.
- R7: A pointer write-back with select 0, 1 or 2 (X, Y, Z) writes both bytes of that pair at one edge; select 3 changes nothing.
- R8: For each register written by more than one source in a cycle, the ALU write wins over pointer write-back, which wins over the data-space write.
- R9: Reset leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (data-space read output only) |
| rd_a_idx_i | input | 5 | Operand A register index |
| rd_a_data_o | output | 8 | Operand A value |
| rd_b_idx_i | input | 5 | Operand B register index |
| rd_b_data_o | output | 8 | Operand B value |
| wr_en_i | input | 1 | ALU result write enable |
| wr_idx_i | input | 5 | ALU result register index |
| wr_data_i | input | 8 | ALU result value |
| ds_req_i | input | 1 | Data-space access request |
| ds_we_i | input | 1 | Data-space access is a write |
| ds_addr_i | input | 16 | Data-space byte address |
| ds_wdata_i | input | 8 | Data-space write value |
| ds_hit_o | output | 1 | Address falls in the register window |
| ds_rdata_o | output | 8 | Registered data-space read value |
| ptr_x_o | output | 16 | X pointer |
| ptr_y_o | output | 16 | Y pointer |
| ptr_z_o | output | 16 | Z pointer, also program-memory lookup address |
| ptr_wr_en_i | input | 1 | Pointer write-back enable |
| ptr_wr_sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wr_data_i | input | 16 | Pointer write-back value |

## Verification
The hardest case is a three-way collision: ALU, pointer write-back and data-space write all striking one pointer pair in the same cycle, with the ALU hitting only one byte so the pair ends up split between two sources. The bench drives all three ports in one cycle aimed at register 30/31 and at 26, then reads each byte back separately to see which source won it. Out-of-window accesses use addresses whose low five bits equal a live register index, so a missing range check would corrupt a known value visibly.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned NREGS    = 32;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 16;
  localparam int unsigned IDX_W    = $clog2(NREGS);
  localparam int unsigned PTR_CNT  = 3;
  localparam int unsigned PTR_BASE = NREGS - 2 * PTR_CNT;

  typedef enum logic [1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/gpr_ds_port.sv
module gpr_ds_port #(
  parameter int unsigned NREGS = gpr_pkg::NREGS,
  parameter int unsigned DW    = gpr_pkg::DW,
  parameter int unsigned AW    = gpr_pkg::AW,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    rd_val_i,
  output logic             hit_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [DW-1:0]    rdata_o
);
  logic rd_go;

  assign hit_o = addr_i < AW'(NREGS);
  assign idx_o = addr_i[IDX_W-1:0];
  assign wr_o  = req_i & we_i & hit_o;
  assign rd_go = req_i & ~we_i & hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_go) rdata_o <= rd_val_i;
  end
endmodule

// File: rtl/gpr_wr_arb.sv
module gpr_wr_arb #(
  parameter int unsigned NREGS   = gpr_pkg::NREGS,
  parameter int unsigned DW      = gpr_pkg::DW,
  parameter int unsigned PTR_CNT = gpr_pkg::PTR_CNT,
  localparam int unsigned IDX_W    = $clog2(NREGS),
  localparam int unsigned PTR_BASE = NREGS - 2 * PTR_CNT
) (
  input  logic                      alu_en_i,
  input  logic [IDX_W-1:0]          alu_idx_i,
  input  logic [DW-1:0]             alu_data_i,
  input  logic                      ptr_en_i,
  input  logic [1:0]                ptr_sel_i,
  input  logic [2*DW-1:0]           ptr_data_i,
  input  logic                      ds_en_i,
  input  logic [IDX_W-1:0]          ds_idx_i,
  input  logic [DW-1:0]             ds_data_i,
  output logic [NREGS-1:0]          reg_we_o,
  output logic [NREGS-1:0][DW-1:0]  reg_wd_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic           alu_hit, ds_hit, ptr_hit;
    logic [DW-1:0]  ptr_byte;

    assign alu_hit = alu_en_i && (alu_idx_i == IDX_W'(i));
    assign ds_hit  = ds_en_i && (ds_idx_i == IDX_W'(i));

    if (i >= PTR_BASE) begin : g_ptr
      localparam int unsigned K  = (i - PTR_BASE) / 2;
      localparam int unsigned HI = (i - PTR_BASE) % 2;
      assign ptr_hit  = ptr_en_i && (ptr_sel_i == 2'(K));
      assign ptr_byte = ptr_data_i[HI*DW +: DW];
    end else begin : g_plain
      assign ptr_hit  = 1'b0;
      assign ptr_byte = '0;
    end

    // ALU > pointer write-back > data space
    always_comb begin
      reg_we_o[i] = alu_hit | ptr_hit | ds_hit;
      if (alu_hit)      reg_wd_o[i] = alu_data_i;
      else if (ptr_hit) reg_wd_o[i] = ptr_byte;
      else              reg_wd_o[i] = ds_data_i;
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned NREGS   = gpr_pkg::NREGS,
  parameter int unsigned DW      = gpr_pkg::DW,
  parameter int unsigned PTR_CNT = gpr_pkg::PTR_CNT,
  localparam int unsigned IDX_W    = $clog2(NREGS),
  localparam int unsigned PTR_BASE = NREGS - 2 * PTR_CNT
) (
  input  logic                          clk_i,
  input  logic [NREGS-1:0]              reg_we_i,
  input  logic [NREGS-1:0][DW-1:0]      reg_wd_i,
  input  logic [IDX_W-1:0]              rd_a_idx_i,
  input  logic [IDX_W-1:0]              rd_b_idx_i,
  input  logic [IDX_W-1:0]              rd_c_idx_i,
  output logic [DW-1:0]                 rd_a_o,
  output logic [DW-1:0]                 rd_b_o,
  output logic [DW-1:0]                 rd_c_o,
  output logic [PTR_CNT-1:0][2*DW-1:0]  ptr_o
);
  logic [NREGS-1:0][DW-1:0] regs_q;

  // contents survive reset by design
  for (genvar i = 0; i < NREGS; i++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (reg_we_i[i]) regs_q[i] <= reg_wd_i[i];
    end
  end

  assign rd_a_o = regs_q[rd_a_idx_i];
  assign rd_b_o = regs_q[rd_b_idx_i];
  assign rd_c_o = regs_q[rd_c_idx_i];

  for (genvar k = 0; k < PTR_CNT; k++) begin : g_ptr
    assign ptr_o[k] = {regs_q[PTR_BASE + 2*k + 1], regs_q[PTR_BASE + 2*k]};
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned NREGS = gpr_pkg::NREGS,
  parameter int unsigned DW    = gpr_pkg::DW,
  parameter int unsigned AW    = gpr_pkg::AW,
  localparam int unsigned IDX_W   = $clog2(NREGS),
  localparam int unsigned PW      = 2 * DW,
  localparam int unsigned PTR_CNT = gpr_pkg::PTR_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [DW-1:0]    rd_a_data_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [DW-1:0]    rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             ds_req_i,
  input  logic             ds_we_i,
  input  logic [AW-1:0]    ds_addr_i,
  input  logic [DW-1:0]    ds_wdata_i,
  output logic             ds_hit_o,
  output logic [DW-1:0]    ds_rdata_o,
  output logic [PW-1:0]    ptr_x_o,
  output logic [PW-1:0]    ptr_y_o,
  output logic [PW-1:0]    ptr_z_o,
  input  logic             ptr_wr_en_i,
  input  logic [1:0]       ptr_wr_sel_i,
  input  logic [PW-1:0]    ptr_wr_data_i
);
  logic [NREGS-1:0]           reg_we;
  logic [NREGS-1:0][DW-1:0]   reg_wd;
  logic [PTR_CNT-1:0][PW-1:0] ptrs;
  logic                       ds_wr;
  logic [IDX_W-1:0]           ds_idx;
  logic [DW-1:0]              ds_val;

  gpr_ds_port #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_ds (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (ds_req_i),
    .we_i     (ds_we_i),
    .addr_i   (ds_addr_i),
    .rd_val_i (ds_val),
    .hit_o    (ds_hit_o),
    .wr_o     (ds_wr),
    .idx_o    (ds_idx),
    .rdata_o  (ds_rdata_o)
  );

  gpr_wr_arb #(.NREGS(NREGS), .DW(DW), .PTR_CNT(PTR_CNT)) u_arb (
    .alu_en_i   (wr_en_i),
    .alu_idx_i  (wr_idx_i),
    .alu_data_i (wr_data_i),
    .ptr_en_i   (ptr_wr_en_i),
    .ptr_sel_i  (ptr_wr_sel_i),
    .ptr_data_i (ptr_wr_data_i),
    .ds_en_i    (ds_wr),
    .ds_idx_i   (ds_idx),
    .ds_data_i  (ds_wdata_i),
    .reg_we_o   (reg_we),
    .reg_wd_o   (reg_wd)
  );

  gpr_store #(.NREGS(NREGS), .DW(DW), .PTR_CNT(PTR_CNT)) u_store (
    .clk_i      (clk_i),
    .reg_we_i   (reg_we),
    .reg_wd_i   (reg_wd),
    .rd_a_idx_i (rd_a_idx_i),
    .rd_b_idx_i (rd_b_idx_i),
    .rd_c_idx_i (ds_idx),
    .rd_a_o     (rd_a_data_o),
    .rd_b_o     (rd_b_data_o),
    .rd_c_o     (ds_val),
    .ptr_o      (ptrs)
  );

  assign ptr_x_o = ptrs[gpr_pkg::PTR_X];
  assign ptr_y_o = ptrs[gpr_pkg::PTR_Y];
  assign ptr_z_o = ptrs[gpr_pkg::PTR_Z];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  rd_a_idx_i,
  input logic [7:0]  rd_a_data_o,
  input logic [4:0]  rd_b_idx_i,
  input logic [7:0]  rd_b_data_o,
  input logic        wr_en_i,
  input logic [4:0]  wr_idx_i,
  input logic [7:0]  wr_data_i,
  input logic        ds_req_i,
  input logic        ds_we_i,
  input logic [15:0] ds_addr_i,
  input logic [7:0]  ds_wdata_i,
  input logic        ds_hit_o,
  input logic [7:0]  ds_rdata_o,
  input logic [15:0] ptr_x_o,
  input logic [15:0] ptr_y_o,
  input logic [15:0] ptr_z_o,
  input logic        ptr_wr_en_i,
  input logic [1:0]  ptr_wr_sel_i,
  input logic [15:0] ptr_wr_data_i
);
  logic ds_load;
  logic alu_on_z;
  assign ds_load  = ds_req_i && !ds_we_i && (ds_addr_i < 16'h0020);
  assign alu_on_z = wr_en_i && (wr_idx_i >= 5'd30);

  // R2
  raw_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) && (rd_a_idx_i == $past(wr_idx_i)) |-> rd_a_data_o == $past(wr_data_i));

  // R4
  ds_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_load && (rd_b_idx_i == ds_addr_i[4:0]) |=> ds_rdata_o == $past(rd_b_data_o));

  // R5
  ds_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_load |=> $stable(ds_rdata_o));

  // R6
  ptr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == 5'd26) |-> rd_a_data_o == ptr_x_o[7:0]);

  // R7
  ptr_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr_en_i && (ptr_wr_sel_i == 2'd2) && !alu_on_z |=> ptr_z_o == $past(ptr_wr_data_i));

  // R3
  always_comb begin
    if (rst_ni) begin
      hit_window_chk: assert (ds_hit_o == (ds_addr_i[15:5] == '0));
    end
  end
endmodule

bind gpr_file gpr_file_chk u_chk (.*);

// File: tb/gpr_file_test.sv
module gpr_file_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [7:0]  rd_a_data_o, rd_b_data_o, wr_data_i = '0, ds_wdata_i = '0, ds_rdata_o;
  logic        wr_en_i = 1'b0, ds_req_i = 1'b0, ds_we_i = 1'b0, ds_hit_o, ptr_wr_en_i = 1'b0;
  logic [15:0] ds_addr_i = '0, ptr_x_o, ptr_y_o, ptr_z_o, ptr_wr_data_i = '0;
  logic [1:0]  ptr_wr_sel_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  gpr_file uut (.*);

  // {index, value}
  localparam logic [12:0] VEC [8] = '{
    {5'd0,  8'h11}, {5'd1,  8'hA5}, {5'd7,  8'h5A}, {5'd15, 8'hFF},
    {5'd16, 8'h00}, {5'd25, 8'h3C}, {5'd26, 8'hC3}, {5'd31, 8'h81}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; ds_req_i = 0; ds_we_i = 0; ptr_wr_en_i = 0;
  endtask

  task automatic alu_wr(logic [4:0] idx, logic [7:0] val);
    @(negedge clk_i); idle(); wr_en_i = 1; wr_idx_i = idx; wr_data_i = val;
    @(negedge clk_i); idle();
  endtask

  task automatic rd_a(logic [4:0] idx, output logic [7:0] v);
    rd_a_idx_i = idx; #1; v = rd_a_data_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    check("R4 reset", {8'h0, ds_rdata_o}, 16'h0000);
    rst_ni = 1;

    // R1 R2 table walk
    foreach (VEC[i]) begin
      alu_wr(VEC[i][12:8], VEC[i][7:0]);
      rd_a_idx_i = VEC[i][12:8]; rd_b_idx_i = VEC[i][12:8]; #1;
      check("R1 port a", {8'h0, rd_a_data_o}, {8'h0, VEC[i][7:0]});
      check("R1 port b", {8'h0, rd_b_data_o}, {8'h0, VEC[i][7:0]});
    end

    // R2 same-cycle read sees old value
    alu_wr(5'd3, 8'h44);
    @(negedge clk_i); wr_en_i = 1; wr_idx_i = 5'd3; wr_data_i = 8'h99;
    rd_a(5'd3, v); check("R2 old value", {8'h0, v}, 16'h0044);
    @(negedge clk_i); idle(); rd_a(5'd3, v); check("R2 new value", {8'h0, v}, 16'h0099);

    // R3 data-space write and window
    @(negedge clk_i); ds_req_i = 1; ds_we_i = 1; ds_addr_i = 16'h0005; ds_wdata_i = 8'h6E;
    #1; check("R3 hit 0x05", {15'h0, ds_hit_o}, 16'h0001);
    @(negedge clk_i); idle(); rd_a(5'd5, v); check("R3 ds write", {8'h0, v}, 16'h006E);
    ds_addr_i = 16'h001F; #1; check("R3 hit 0x1F", {15'h0, ds_hit_o}, 16'h0001);
    ds_addr_i = 16'h0020; #1; check("R3 hit 0x20", {15'h0, ds_hit_o}, 16'h0000);

    // R4 data-space read, then hold
    @(negedge clk_i); ds_req_i = 1; ds_we_i = 0; ds_addr_i = 16'h0007;
    @(negedge clk_i); idle(); check("R4 ds read", {8'h0, ds_rdata_o}, 16'h005A);
    ds_addr_i = 16'h0001;
    @(negedge clk_i); check("R4 hold", {8'h0, ds_rdata_o}, 16'h005A);

    // R5 out-of-window accesses alias low bits onto live registers
    @(negedge clk_i); ds_req_i = 1; ds_we_i = 1; ds_addr_i = 16'h0025; ds_wdata_i = 8'hEE;
    @(negedge clk_i); idle(); rd_a(5'd5, v); check("R5 write ignored", {8'h0, v}, 16'h006E);
    @(negedge clk_i); ds_req_i = 1; ds_we_i = 0; ds_addr_i = 16'h0101;
    @(negedge clk_i); idle(); check("R5 read ignored", {8'h0, ds_rdata_o}, 16'h005A);

    // R6 pointer pairs
    alu_wr(5'd26, 8'h10); alu_wr(5'd27, 8'h20);
    alu_wr(5'd28, 8'h30); alu_wr(5'd29, 8'h40);
    alu_wr(5'd30, 8'h50); alu_wr(5'd31, 8'h60);
    check("R6 X", ptr_x_o, 16'h2010);
    check("R6 Y", ptr_y_o, 16'h4030);
    check("R6 Z", ptr_z_o, 16'h6050);

    // R7 write-back of Y, then select 3
    @(negedge clk_i); ptr_wr_en_i = 1; ptr_wr_sel_i = 2'd1; ptr_wr_data_i = 16'hBEEF;
    @(negedge clk_i); idle();
    check("R7 Y", ptr_y_o, 16'hBEEF);
    rd_a(5'd28, v); check("R7 low byte r28", {8'h0, v}, 16'h00EF);
    @(negedge clk_i); ptr_wr_en_i = 1; ptr_wr_sel_i = 2'd3; ptr_wr_data_i = 16'h1234;
    @(negedge clk_i); idle();
    check("R7 sel3 X", ptr_x_o, 16'h2010);
    check("R7 sel3 Y", ptr_y_o, 16'hBEEF);
    check("R7 sel3 Z", ptr_z_o, 16'h6050);

    // R8 three-way collision on Z pair
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 5'd30; wr_data_i = 8'hA1;
    ptr_wr_en_i = 1; ptr_wr_sel_i = 2'd2; ptr_wr_data_i = 16'hBBCC;
    ds_req_i = 1; ds_we_i = 1; ds_addr_i = 16'h001F; ds_wdata_i = 8'hDD;
    @(negedge clk_i); idle();
    check("R8 alu over ptr", ptr_z_o, 16'hBBA1);
    // pointer over data space
    @(negedge clk_i);
    ptr_wr_en_i = 1; ptr_wr_sel_i = 2'd0; ptr_wr_data_i = 16'h1234;
    ds_req_i = 1; ds_we_i = 1; ds_addr_i = 16'h001A; ds_wdata_i = 8'h77;
    @(negedge clk_i); idle();
    check("R8 ptr over ds", ptr_x_o, 16'h1234);
    // ALU over data space
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 5'd7; wr_data_i = 8'h3E;
    ds_req_i = 1; ds_we_i = 1; ds_addr_i = 16'h0007; ds_wdata_i = 8'hC0;
    @(negedge clk_i); idle(); rd_a(5'd7, v); check("R8 alu over ds", {8'h0, v}, 16'h003E);

    // R9 reset keeps contents
    @(negedge clk_i); ds_req_i = 1; ds_we_i = 0; ds_addr_i = 16'h0003;
    @(negedge clk_i); idle(); check("R4 read r3", {8'h0, ds_rdata_o}, 16'h0099);
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    check("R4 reset clears", {8'h0, ds_rdata_o}, 16'h0000);
    rst_ni = 1;
    @(negedge clk_i);
    rd_a(5'd3, v); check("R9 r3 kept", {8'h0, v}, 16'h0099);
    check("R9 Y kept", ptr_y_o, 16'hBEEF);

    finish_run();
  end
endmodule